// File: doc/BRIEF.md
# Double-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two IEEE-754 binary64 operands (1 sign bit, 11 exponent bits, 52 fraction bits) over several clock cycles. It accepts subnormal operands and produces subnormal results through gradual underflow. A subnormal sum that carries into the hidden bit becomes the smallest normal number. A normal difference that cancels below the normal range falls back to the subnormal encoding. Subtraction runs as addition with the sign of operand B flipped. The aligned significand carries guard, round and sticky bits, and the result is rounded in one of four directions.

A caller places the operands, the operation select and the rounding direction on the inputs, then raises `start_en` for two cycles. The inputs are captured on the first rising edge that sees `start_en` high while the unit is idle or finished. The unit walks a fixed sequence of states. ST_IDLE goes to ST_UNPACK when a start is sampled. ST_UNPACK (classify and order the operands) goes to ST_ALIGN (shift the smaller significand). ST_ALIGN goes to ST_ADD (add or subtract the magnitudes), then to ST_NORM (carry shift or leading-zero shift), then to ST_ROUND (round, pack and handle specials). ST_ROUND goes to ST_HOLD, which pads the run until the fixed latency is reached. ST_HOLD then goes to ST_DONE. ST_DONE stays put until another start is sampled, which takes it back to ST_UNPACK.

Top module: `fpadd_dp`

## Requirements
- R1: With rounding to nearest-even, `res_out` equals the correctly rounded binary64 value of A+B when `op_sub`=0, and of A-B (A plus B with its sign inverted) when `op_sub`=1.
- R2: `rnd_mode` selects the rounding direction: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R3: Subnormal operands (exponent field 0, no hidden bit) are accepted. Subnormal results are produced without flushing. A subnormal carry yields exponent field 1. A normal result that cancels below the normal range yields exponent field 0.
- R4: An exact zero result from an effective subtraction is +0, except when rounding toward -infinity, where it is -0. Two zeros of the same sign sum to a zero of that sign.
- R5: A start is sampled when `start_en` is high at a rising edge in ST_IDLE or ST_DONE. `done` rises exactly 20 rising edges after the start edge when `op_sub`=0, and exactly 21 when `op_sub`=1. `start_en` is ignored while busy.
- R6: While `done` is high and no new start is sampled, `done` and `res_out` hold steady. `done` falls in the cycle after a new start is sampled.
- R7: A synchronous reset clears `done`, `res_out`, `flag_invalid`, `flag_overflow` and `flag_inexact` to 0.
- R8: A NaN is an all-ones exponent with a nonzero fraction. It is signalling when fraction bit 51 is 0. A signalling NaN operand raises `flag_invalid`. The result is the first NaN operand (A before B) with bit 51 set. A quiet NaN operand alone does not raise `flag_invalid`.
- R9: An infinity combined with a finite value returns that infinity, with B's sign inverted under subtraction. An effective subtraction of two infinities returns 64'h7FF8000000000000 and raises `flag_invalid`.
- R10: When the rounded magnitude exceeds the largest finite value, `flag_overflow` and `flag_inexact` are set. The result is infinity when rounding to nearest or when rounding away from zero in the result's direction. Otherwise it is the largest finite value 0x7FEFFFFFFFFFFFFF with the result's sign.
- R11: `flag_inexact` is set exactly when the delivered finite result differs from the exact sum. Bits shifted out during alignment are never lost from this decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Start request, held high two cycles by the caller |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| rnd_mode | input | 2 | Rounding direction code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| res_out | output | 64 | Rounded result |
| done | output | 1 | Result valid |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Overflow |
| flag_inexact | output | 1 | Inexact result |

## Verification
The assertions assume the caller never expects an operation to begin while the unit is busy. They also assume a second start request is only meaningful once `done` is high, so stability of `res_out` is checked only across cycles with `start_en` low. The stimulus keeps to this: every operation raises `start_en` for exactly two cycles and then waits for `done`. Random operands never carry an all-ones exponent field, so infinities and NaNs come only from the directed cases. Random exponents are drawn close together, and some are drawn near zero, so that cancellation, carries and subnormal crossings occur often.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [1:0] {
        RND_NEAREST_EVEN = 2'b00,
        RND_TO_ZERO      = 2'b01,
        RND_TO_POS       = 2'b10,
        RND_TO_NEG       = 2'b11
    } rnd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNPACK,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_ROUND,
        ST_HOLD,
        ST_DONE
    } fsm_state_e;

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] opa,
    input  logic [EXP_W+FRAC_W:0] opb,
    input  logic                  op_sub,
    output logic                  big_sign,
    output logic                  small_sign,
    output logic [EXP_W-1:0]      big_exp,
    output logic [FRAC_W:0]       big_sig,
    output logic [FRAC_W:0]       small_sig,
    output logic [EXP_W-1:0]      exp_diff,
    output logic                  is_special,
    output logic [EXP_W+FRAC_W:0] special_res,
    output logic                  special_invalid
);
    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(1);
    localparam logic [W-1:0] QUIET_BIT = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DEFAULT_NAN = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    logic              sa, sb;
    logic [EXP_W-1:0]  ea, eb, ea_eff, eb_eff;
    logic [FRAC_W-1:0] fa, fb;
    logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_first;

    always_comb begin
        sa     = opa[W-1];
        sb     = opb[W-1] ^ op_sub;
        ea     = opa[W-2 -: EXP_W];
        eb     = opb[W-2 -: EXP_W];
        fa     = opa[FRAC_W-1:0];
        fb     = opb[FRAC_W-1:0];
        ea_eff = (ea == '0) ? EXP_ONE : ea;
        eb_eff = (eb == '0) ? EXP_ONE : eb;
        a_nan  = (ea == EXP_ONES) && (fa != '0);
        b_nan  = (eb == EXP_ONES) && (fb != '0);
        a_snan = a_nan && !fa[FRAC_W-1];
        b_snan = b_nan && !fb[FRAC_W-1];
        a_inf  = (ea == EXP_ONES) && (fa == '0);
        b_inf  = (eb == EXP_ONES) && (fb == '0);
        a_first = (opa[W-2:0] >= opb[W-2:0]);

        if (a_first) begin
            big_sign   = sa;
            small_sign = sb;
            big_exp    = ea_eff;
            big_sig    = {ea != '0, fa};
            small_sig  = {eb != '0, fb};
            exp_diff   = ea_eff - eb_eff;
        end else begin
            big_sign   = sb;
            small_sign = sa;
            big_exp    = eb_eff;
            big_sig    = {eb != '0, fb};
            small_sig  = {ea != '0, fa};
            exp_diff   = eb_eff - ea_eff;
        end

        is_special      = a_nan || b_nan || a_inf || b_inf;
        special_invalid = a_snan || b_snan || (a_inf && b_inf && (sa != sb) && !a_nan && !b_nan);
        if (a_nan)                          special_res = opa | QUIET_BIT;
        else if (b_nan)                     special_res = opb | QUIET_BIT;
        else if (a_inf && b_inf && sa != sb) special_res = DEFAULT_NAN;
        else if (a_inf)                     special_res = opa;
        else                                special_res = {sb, opb[W-2:0]};
    end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int SIG_W = 53,
    parameter int SH_W  = 11
) (
    input  logic [SIG_W-1:0]  sig_in,
    input  logic [SH_W-1:0]   shift,
    output logic [SIG_W+2:0]  aligned
);
    localparam int EXT_W = SIG_W + 3;
    localparam logic [SH_W-1:0] SH_LIM = SH_W'(EXT_W);

    logic [EXT_W-1:0] ext, mask;

    always_comb begin
        ext = {sig_in, 3'b000};
        if (shift >= SH_LIM) begin
            mask    = '1;
            aligned = {{(EXT_W-1){1'b0}}, |ext};
        end else begin
            mask    = ~({EXT_W{1'b1}} << shift);
            aligned = (ext >> shift) | {{(EXT_W-1){1'b0}}, |(ext & mask)};
        end
    end

    // R11: a nonzero operand never vanishes entirely during alignment
    always_comb begin
        p_sticky_keep_r11: assert ((aligned != '0) || (sig_in == '0))
            else $error("aligned operand lost all bits");
    end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
    parameter int N  = 56,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] zeros
);
    logic found;

    always_comb begin
        zeros = CW'(N);
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                zeros = CW'(N - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                  sign,
    input  logic [EXP_W+1:0]      exp_in,
    input  logic [FRAC_W+3:0]     sig_in,
    input  logic [1:0]            rm,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  ovf,
    output logic                  inx
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int XW    = EXP_W + 2;
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [EXP_W-1:0] EXP_TOP  = {{(EXP_W-1){1'b1}}, 1'b0};
    localparam logic [XW-1:0]    EXP_LIM  = {2'b00, EXP_ONES};

    logic [SIG_W-1:0] m, mf;
    logic [SIG_W:0]   mr;
    logic [XW-1:0]    ef;
    logic             g, r, s, lost, up, to_inf;

    always_comb begin
        m    = sig_in[EXT_W-1:3];
        g    = sig_in[2];
        r    = sig_in[1];
        s    = sig_in[0];
        lost = g | r | s;
        unique case (rnd_mode_e'(rm))
            RND_NEAREST_EVEN: up = g & (r | s | m[0]);
            RND_TO_ZERO:      up = 1'b0;
            RND_TO_POS:       up = lost & ~sign;
            RND_TO_NEG:       up = lost & sign;
        endcase
        mr = {1'b0, m} + (SIG_W+1)'(up);
        if (mr[SIG_W]) begin
            mf = mr[SIG_W:1];
            ef = exp_in + XW'(1);
        end else begin
            mf = mr[SIG_W-1:0];
            ef = exp_in;
        end
        ovf    = (ef >= EXP_LIM);
        to_inf = (rnd_mode_e'(rm) == RND_NEAREST_EVEN) ||
                 (rnd_mode_e'(rm) == RND_TO_POS && !sign) ||
                 (rnd_mode_e'(rm) == RND_TO_NEG && sign);
        if (ovf)
            res = to_inf ? {sign, EXP_ONES, {FRAC_W{1'b0}}} : {sign, EXP_TOP, {FRAC_W{1'b1}}};
        else
            res = {sign, mf[SIG_W-1] ? ef[EXP_W-1:0] : {EXP_W{1'b0}}, mf[FRAC_W-1:0]};
        inx = lost | ovf;
    end
endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
    import fpadd_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int ADD_LAT = 20,
    parameter int SUB_LAT = 21
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_en,
    input  logic                  op_sub,
    input  logic [1:0]            rnd_mode,
    input  logic [EXP_W+FRAC_W:0] opa,
    input  logic [EXP_W+FRAC_W:0] opb,
    output logic [EXP_W+FRAC_W:0] res_out,
    output logic                  done,
    output logic                  flag_invalid,
    output logic                  flag_overflow,
    output logic                  flag_inexact
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;
    localparam int XW     = EXP_W + 2;
    localparam int LZW    = $clog2(EXT_W + 1);
    localparam int MAXLAT = (ADD_LAT > SUB_LAT) ? ADD_LAT : SUB_LAT;
    localparam int CW     = $clog2(MAXLAT + 2);

    fsm_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, lat_w;
    logic start, busy;

    logic [W-1:0]  a_q, b_q;
    logic          sub_q;
    rnd_mode_e     rm_q;

    logic             u_bs, u_ss, u_spec, u_inv;
    logic [EXP_W-1:0] u_be, u_diff;
    logic [SIG_W-1:0] u_bsig, u_ssig;
    logic [W-1:0]     u_sres;

    logic             bs_q, effsub_q, spec_q, sinv_q;
    logic [EXP_W-1:0] be_q, diff_q;
    logic [SIG_W-1:0] bsig_q, ssig_q;
    logic [W-1:0]     sres_q;

    logic [EXT_W-1:0] al_w, sal_q;
    logic [EXT_W:0]   sum_q;
    logic [LZW-1:0]   lz_w;
    logic [XW-1:0]    room_w, sh_w, nexp_d, nexp_q;
    logic [EXT_W-1:0] norm_d, norm_q;
    logic             zero_q;

    logic [W-1:0] rnd_res;
    logic         rnd_ovf, rnd_inx, z_sign;
    logic [W-1:0] res_q;
    logic         inv_q, ovf_q, inx_q;

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .opa(a_q), .opb(b_q), .op_sub(sub_q),
        .big_sign(u_bs), .small_sign(u_ss), .big_exp(u_be),
        .big_sig(u_bsig), .small_sig(u_ssig), .exp_diff(u_diff),
        .is_special(u_spec), .special_res(u_sres), .special_invalid(u_inv)
    );

    fpadd_align #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_align (
        .sig_in(ssig_q), .shift(diff_q), .aligned(al_w)
    );

    fpadd_lzc #(.N(EXT_W), .CW(LZW)) u_lzc (
        .vec(sum_q[EXT_W-1:0]), .zeros(lz_w)
    );

    fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign(bs_q), .exp_in(nexp_q), .sig_in(norm_q), .rm(rm_q),
        .res(rnd_res), .ovf(rnd_ovf), .inx(rnd_inx)
    );

    assign start = start_en && (state_q == ST_IDLE || state_q == ST_DONE);
    assign busy  = !(state_q == ST_IDLE || state_q == ST_DONE);
    assign lat_w = sub_q ? CW'(SUB_LAT) : CW'(ADD_LAT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_en) state_d = ST_UNPACK;
            ST_UNPACK: state_d = ST_ALIGN;
            ST_ALIGN:  state_d = ST_ADD;
            ST_ADD:    state_d = ST_NORM;
            ST_NORM:   state_d = ST_ROUND;
            ST_ROUND:  state_d = ST_HOLD;
            ST_HOLD:   if (cnt_q == lat_w) state_d = ST_DONE;
            ST_DONE:   if (start_en) state_d = ST_UNPACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)     cnt_q <= CW'(1);
            else if (busy) cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        room_w = {2'b00, be_q} - XW'(1);
        sh_w   = (XW'(lz_w) < room_w) ? XW'(lz_w) : room_w;
        if (sum_q[EXT_W]) begin
            norm_d = {sum_q[EXT_W:2], |sum_q[1:0]};
            nexp_d = {2'b00, be_q} + XW'(1);
        end else begin
            norm_d = sum_q[EXT_W-1:0] << sh_w;
            nexp_d = {2'b00, be_q} - sh_w;
        end
        z_sign = effsub_q ? (rm_q == RND_TO_NEG) : bs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0; b_q <= '0; sub_q <= 1'b0; rm_q <= RND_NEAREST_EVEN;
            bs_q <= 1'b0; effsub_q <= 1'b0; spec_q <= 1'b0; sinv_q <= 1'b0;
            be_q <= '0; diff_q <= '0; bsig_q <= '0; ssig_q <= '0; sres_q <= '0;
            sal_q <= '0; sum_q <= '0; norm_q <= '0; nexp_q <= '0; zero_q <= 1'b0;
            res_q <= '0; inv_q <= 1'b0; ovf_q <= 1'b0; inx_q <= 1'b0;
        end else begin
            if (start) begin
                a_q   <= opa;
                b_q   <= opb;
                sub_q <= op_sub;
                rm_q  <= rnd_mode_e'(rnd_mode);
            end
            unique case (state_q)
                ST_UNPACK: begin
                    bs_q     <= u_bs;
                    effsub_q <= u_bs ^ u_ss;
                    be_q     <= u_be;
                    diff_q   <= u_diff;
                    bsig_q   <= u_bsig;
                    ssig_q   <= u_ssig;
                    spec_q   <= u_spec;
                    sinv_q   <= u_inv;
                    sres_q   <= u_sres;
                end
                ST_ALIGN: sal_q <= al_w;
                ST_ADD: begin
                    if (effsub_q) sum_q <= {1'b0, bsig_q, 3'b000} - {1'b0, sal_q};
                    else          sum_q <= {1'b0, bsig_q, 3'b000} + {1'b0, sal_q};
                end
                ST_NORM: begin
                    norm_q <= norm_d;
                    nexp_q <= nexp_d;
                    zero_q <= (sum_q == '0);
                end
                ST_ROUND: begin
                    if (spec_q) begin
                        res_q <= sres_q; inv_q <= sinv_q; ovf_q <= 1'b0; inx_q <= 1'b0;
                    end else if (zero_q) begin
                        res_q <= {z_sign, {(W-1){1'b0}}};
                        inv_q <= 1'b0; ovf_q <= 1'b0; inx_q <= 1'b0;
                    end else begin
                        res_q <= rnd_res; inv_q <= 1'b0; ovf_q <= rnd_ovf; inx_q <= rnd_inx;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done          = (state_q == ST_DONE);
        res_out       = res_q;
        flag_invalid  = inv_q;
        flag_overflow = ovf_q;
        flag_inexact  = inx_q;
    end

    // R5: done rises only once the full latency of the requested operation has elapsed
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt_q == lat_w + CW'(1)));
    // R6: a finished result stays put while no new start arrives
    p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start_en) |=> (done && $stable(res_out)));
    // R6: a start sampled while done clears done next cycle
    p_drop_done_r6: assert property (@(posedge clk) disable iff (rst)
        (done && start_en) |=> !done);
    // R8: any NaN delivered is quiet
    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (done && (&res_out[W-2 -: EXP_W]) && (|res_out[FRAC_W-1:0])) |-> res_out[FRAC_W-1]);
    // R8: invalid always comes with a quiet NaN result
    p_invalid_nan_r8: assert property (@(posedge clk) disable iff (rst)
        (done && flag_invalid) |-> ((&res_out[W-2 -: EXP_W]) && res_out[FRAC_W-1]));
    // R10: overflow implies inexact
    p_ovf_inexact_r10: assert property (@(posedge clk) disable iff (rst)
        (done && flag_overflow) |-> flag_inexact);
endmodule

// File: tb/fpadd_dp_test.sv
module fpadd_dp_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_en = 1'b0;
    logic        op_sub = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic [63:0] opa = '0, opb = '0;
    logic [63:0] res_out;
    logic        done, flag_invalid, flag_overflow, flag_inexact;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;

    fpadd_dp uut (
        .clk(clk), .rst(rst), .start_en(start_en), .op_sub(op_sub), .rnd_mode(rnd_mode),
        .opa(opa), .opb(opb), .res_out(res_out), .done(done),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow), .flag_inexact(flag_inexact)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] step_up(input logic [63:0] x);
        if (x[62:0] == '0) return 64'h1;
        return x[63] ? x - 64'd1 : x + 64'd1;
    endfunction

    function automatic logic [63:0] step_dn(input logic [63:0] x);
        if (x[62:0] == '0) return 64'h8000_0000_0000_0001;
        return x[63] ? x + 64'd1 : x - 64'd1;
    endfunction

    // Reference for finite operands: host sum plus an error-free error term
    task automatic model(input logic [63:0] a, input logic [63:0] b, input bit sub,
                         input logic [1:0] m, output logic [63:0] r,
                         output bit ovf, output bit inx);
        real ra, rb, s, bb, err;
        logic [63:0] sbits, bq;
        bq = b ^ {sub, 63'b0};
        ra = $bitstoreal(a);
        rb = $bitstoreal(bq);
        s = ra + rb;
        sbits = $realtobits(s);
        ovf = 1'b0;
        inx = 1'b0;
        if (sbits[62:52] == 11'h7FF) begin
            ovf = 1'b1; inx = 1'b1;
            case (m)
                2'b00: r = sbits;
                2'b01: r = {sbits[63], MAXF[62:0]};
                2'b10: r = sbits[63] ? {1'b1, MAXF[62:0]} : sbits;
                default: r = sbits[63] ? sbits : MAXF;
            endcase
            return;
        end
        bb = s - ra;
        err = (ra - (s - bb)) + (rb - bb);
        r = sbits;
        if (err != 0.0) begin
            inx = 1'b1;
            case (m)
                2'b01: if (s > 0.0 && err < 0.0) r = step_dn(sbits);
                       else if (s < 0.0 && err > 0.0) r = step_up(sbits);
                2'b10: if (err > 0.0) r = step_up(sbits);
                2'b11: if (err < 0.0) r = step_dn(sbits);
                default: ;
            endcase
            if (r[62:52] == 11'h7FF) ovf = 1'b1;
        end else if (s == 0.0) begin
            r = {(a[63] == bq[63]) ? a[63] : (m == 2'b11), 63'b0};
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit sub,
                          input logic [1:0] m, output int lat);
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; rnd_mode = m; start_en = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        check(done == 1'b0, "R6", "done after start", {63'b0, done}, 64'h0);
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_en = 1'b0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic op_check(input logic [63:0] a, input logic [63:0] b, input bit sub,
                            input logic [1:0] m, input string req);
        int lat;
        logic [63:0] er;
        bit eo, ei;
        run_op(a, b, sub, m, lat);
        check(lat == (sub ? 21 : 20), "R5", "latency", 64'(lat), sub ? 64'd21 : 64'd20);
        model(a, b, sub, m, er, eo, ei);
        check(res_out == er, req, "result", res_out, er);
        check(flag_overflow == eo, "R10", "overflow", {63'b0, flag_overflow}, {63'b0, eo});
        check(flag_inexact == ei, "R11", "inexact", {63'b0, flag_inexact}, {63'b0, ei});
        check(flag_invalid == 1'b0, "R8", "invalid", {63'b0, flag_invalid}, 64'h0);
    endtask

    task automatic spec_check(input logic [63:0] a, input logic [63:0] b, input bit sub,
                              input logic [63:0] er, input bit einv, input string req);
        int lat;
        run_op(a, b, sub, 2'b00, lat);
        check(res_out == er, req, "special result", res_out, er);
        check(flag_invalid == einv, req, "invalid", {63'b0, flag_invalid}, {63'b0, einv});
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset state
        check(done == 1'b0 && res_out == '0, "R7", "reset outputs", res_out, 64'h0);
        check({flag_invalid, flag_overflow, flag_inexact} == 3'b0, "R7", "reset flags",
              {61'b0, flag_invalid, flag_overflow, flag_inexact}, 64'h0);

        // R1: basic add and subtract
        op_check(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 2'b00, "R1");
        op_check(64'h4014_0000_0000_0000, 64'h3FF8_0000_0000_0000, 1'b1, 2'b00, "R1");
        // R3: subnormal carry to smallest normal, cancellation into subnormal
        op_check(64'h000F_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 2'b00, "R3");
        check(res_out == 64'h0010_0000_0000_0000, "R3", "promotion", res_out, 64'h0010_0000_0000_0000);
        op_check(64'h0010_0000_0000_0001, 64'h0010_0000_0000_0000, 1'b1, 2'b00, "R3");
        check(res_out == 64'h1, "R3", "demotion", res_out, 64'h1);
        // R4: exact zero signs
        op_check(64'h4009_21FB_5444_2D18, 64'h4009_21FB_5444_2D18, 1'b1, 2'b00, "R4");
        check(res_out == 64'h0, "R4", "+0 nearest", res_out, 64'h0);
        op_check(64'h4009_21FB_5444_2D18, 64'h4009_21FB_5444_2D18, 1'b1, 2'b11, "R4");
        check(res_out == 64'h8000_0000_0000_0000, "R4", "-0 downward", res_out, 64'h8000_0000_0000_0000);
        op_check(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'b00, "R4");
        // R2: tie and directed rounding of 1 + 2^-53
        for (int m = 0; m < 4; m++)
            op_check(64'h3FF0_0000_0000_0000, 64'h3CA0_0000_0000_0000, 1'b0, 2'(m), "R2");
        op_check(64'hBFF0_0000_0000_0000, 64'h3CA8_0000_0000_0000, 1'b1, 2'b01, "R2");
        // R10: overflow per mode
        for (int m = 0; m < 4; m++)
            op_check(MAXF, MAXF, 1'b0, 2'(m), "R10");
        op_check(64'hFFEF_FFFF_FFFF_FFFF, MAXF, 1'b1, 2'b10, "R10");
        // R8 / R9: specials
        spec_check(64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0,
                   64'h7FF8_0000_0000_0001, 1'b1, "R8");
        spec_check(64'h3FF0_0000_0000_0000, 64'hFFF8_0000_0000_0005, 1'b0,
                   64'hFFF8_0000_0000_0005, 1'b0, "R8");
        spec_check(64'h7FF8_0000_0000_0002, 64'h7FF0_0000_0000_0003, 1'b0,
                   64'h7FF8_0000_0000_0002, 1'b1, "R8");
        spec_check(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1,
                   64'h7FF8_0000_0000_0000, 1'b1, "R9");
        spec_check(64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1,
                   64'hFFF0_0000_0000_0000, 1'b0, "R9");
        spec_check(64'hFFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0,
                   64'hFFF0_0000_0000_0000, 1'b0, "R9");

        // R6: result and done hold while idle after completion
        held = res_out;
        repeat (6) @(negedge clk);
        check(done == 1'b1 && res_out == held, "R6", "hold", res_out, held);

        // Random operands, exponents kept close, some near the subnormal range
        for (int i = 0; i < 400; i++) begin
            int e1, e2, d;
            logic [63:0] a, b;
            e1 = (i % 6 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 2046));
            d  = int'($urandom_range(0, 60));
            e2 = ($urandom_range(0, 1) == 1) ? e1 + d : e1 - d;
            if (e2 < 0) e2 = 0;
            if (e2 > 2046) e2 = 2046;
            a = {1'($urandom_range(0, 1)), 11'(e1), 20'($urandom), 32'($urandom)};
            b = {1'($urandom_range(0, 1)), 11'(e2), 20'($urandom), 32'($urandom)};
            if (i % 5 == 0) b[51:0] = a[51:0] ^ 52'($urandom_range(0, 7));
            op_check(a, b, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R1 R2 R3");
        end

        // R7: reset during an operation clears the outputs
        @(negedge clk);
        opa = 64'h3FF0_0000_0000_0000; opb = opa; op_sub = 1'b0; start_en = 1'b1;
        repeat (2) @(negedge clk);
        start_en = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done == 1'b0 && res_out == '0, "R7", "mid-run reset", res_out, 64'h0);
        run_op(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 2'b00, lat);
        check(lat == 20 && res_out == 64'h4000_0000_0000_0000, "R5", "after reset",
              res_out, 64'h4000_0000_0000_0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule